// File: doc/BRIEF.md
# Raster-to-block line buffer

This block sits between a host that delivers an image one line at a time and an encoder that needs the image as 8x8 tiles. Pixels come in on a valid/ready stream in raster order: left to right along a line, then line after line. They are stored in an on-chip RAM that is split into two bands of eight lines each. Once a band holds eight complete lines, the read side sends that band out one tile at a time. Tiles go left to right across the image. Inside each tile, pixels come out row by row, and left to right within a row.

The two bands are used in turn. The host fills one band while the other is being read out. The host is held off only when both bands hold data that has not yet been read. The image width is set at run time through `cfg_width`. It must be a multiple of 8 and no larger than the parameter `MAX_W`. The image height is set through `cfg_bands`, counted in 8-line bands. Both settings must stay constant for the whole of a frame. Three flags travel with each output pixel: one marks the end of a tile, one the end of a band, and one the end of the image.

Top module: `rblk_buffer`

## Requirements
- R1: While reset is applied and right after it, `rd_valid` is 0. `wr_ready` is 0 while reset is applied and becomes 1 within three cycles of reset release.
- R2: A pixel is taken from the host on every rising edge where `wr_valid` and `wr_ready` are both 1. Pixels are taken in raster order for a width of `cfg_width` (a multiple of 8, at most `MAX_W`) and a height of 8*`cfg_bands` lines.
- R3: Output pixel number 8*r+c of tile k in band b is the input pixel at line 8*b+r and column 8*k+c, for r and c from 0 to 7. Tiles come out in increasing k, and bands in increasing b.
- R4: `rd_valid` stays 0 until all 8*`cfg_width` pixels of the next band to be read have been taken.
- R5: While `rd_valid` is 1 and `rd_ready` is 0, the outputs `rd_valid`, `rd_pix` and all three flags hold their values into the next cycle.
- R6: `wr_ready` is 0 while both bands hold unread data, and no accepted pixel is ever overwritten before it is read.
- R7: `rd_blk_last` is 1 on exactly the 64th pixel of every tile.
- R8: `rd_band_done` is 1 only on the last pixel of the rightmost tile of a band.
- R9: `rd_eoi` is 1 only on the last pixel of the last band of the image. The next pixel taken after the last input pixel of an image starts a new image at line 0.
- R10: After one band has been filled and while it is still unread, `wr_ready` stays 1 so the host can start filling the other band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | $clog2(MAX_W+1) | Image width in pixels, a multiple of 8 |
| cfg_bands | input | $clog2(MAX_BANDS+1) | Image height in 8-line bands, at least 1 |
| wr_valid | input | 1 | Host pixel present |
| wr_ready | output | 1 | Buffer can take a pixel |
| wr_pix | input | PIX_W | Host pixel, raster order |
| rd_valid | output | 1 | Output pixel present |
| rd_ready | input | 1 | Consumer takes the output pixel |
| rd_pix | output | PIX_W | Output pixel, tile order |
| rd_blk_last | output | 1 | Last pixel of a tile |
| rd_band_done | output | 1 | Last pixel of a band |
| rd_eoi | output | 1 | Last pixel of the image |

## Verification
The bench first writes a band that is one pixel short and checks that nothing comes out. A design that started reading too early would send stale RAM contents. With the reader stopped, it then fills both bands and checks that the host is held off. A design with wrong ping-pong handling would either overwrite unread pixels or stall the host after the first band. Every output pixel is compared with a model of the tile ordering at three widths: two tiles, the full `MAX_W`, and a single tile. The read side is stalled in an irregular pattern, so a wrong row stride, a wrong tile offset, a lost hold under backpressure, or a flag one pixel early or late shows up as a mismatch against the queue.

// File: rtl/rblk_pkg.sv
package rblk_pkg;
  // Number of 8-line bands used in ping-pong fashion.
  localparam int NBANDS = 2;
  // Tile edge length in pixels.
  localparam int TILE = 8;

  typedef struct packed {
    logic blk_last;
    logic band_done;
    logic img_end;
  } rblk_tag_t;
endpackage

// File: rtl/rblk_ram.sv
module rblk_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Synchronous read; this register is the output pixel register.
  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/rblk_band_track.sv
module rblk_band_track
  import rblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              set_sel,
  input  logic              clr_en,
  input  logic              clr_sel,
  output logic [NBANDS-1:0] full
);
  logic [NBANDS-1:0] full_d;

  for (genvar g = 0; g < NBANDS; g++) begin : g_band
    always_comb begin
      full_d[g] = full[g];
      if (set_en && (int'(set_sel) == g)) full_d[g] = 1'b1;
      if (clr_en && (int'(clr_sel) == g)) full_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) full[g] <= 1'b0;
      else        full[g] <= full_d[g];
    end
  end
endmodule

// File: rtl/rblk_wr_ctrl.sv
module rblk_wr_ctrl #(
  parameter int MAX_W  = 64,
  parameter int WID_W  = $clog2(MAX_W + 1),
  parameter int OFF_W  = $clog2(8 * MAX_W),
  parameter int ADDR_W = $clog2(16 * MAX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              wr_valid,
  input  logic              band_busy,
  output logic              wr_ready,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              sel,
  output logic              band_filled
);
  localparam int LEN_W      = WID_W + 3;
  localparam int BAND_DEPTH = 8 * MAX_W;

  logic [OFF_W-1:0] off_q, off_d;
  logic             sel_d;
  logic [LEN_W-1:0] band_len;
  logic             at_end;

  assign wr_ready    = rst_n && !band_busy;
  assign we          = wr_valid && wr_ready;
  assign band_len    = {cfg_width, 3'b000};
  assign at_end      = (LEN_W'(off_q) == band_len - LEN_W'(1));
  assign band_filled = we && at_end;
  assign waddr       = (sel ? ADDR_W'(BAND_DEPTH) : ADDR_W'(0)) + ADDR_W'(off_q);

  always_comb begin
    off_d = off_q;
    sel_d = sel;
    if (we) begin
      if (at_end) begin
        off_d = '0;
        sel_d = !sel;
      end else begin
        off_d = off_q + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      sel   <= 1'b0;
    end else begin
      off_q <= off_d;
      sel   <= sel_d;
    end
  end
endmodule

// File: rtl/rblk_rd_ctrl.sv
module rblk_rd_ctrl
  import rblk_pkg::*;
#(
  parameter int MAX_W     = 64,
  parameter int MAX_BANDS = 256,
  parameter int WID_W     = $clog2(MAX_W + 1),
  parameter int BCNT_W    = $clog2(MAX_BANDS + 1),
  parameter int OFF_W     = $clog2(8 * MAX_W),
  parameter int ADDR_W    = $clog2(16 * MAX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [BCNT_W-1:0] cfg_bands,
  input  logic [NBANDS-1:0] band_full,
  input  logic              rd_ready,
  output logic              rd_valid,
  output rblk_tag_t         tag,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              band_clr,
  output logic              sel
);
  localparam int BAND_DEPTH = 8 * MAX_W;
  localparam int BX_W       = (MAX_W / TILE > 1) ? $clog2(MAX_W / TILE) : 1;

  logic [2:0]        col_q, col_d, row_q, row_d;
  logic [BX_W-1:0]   bx_q, bx_d;
  logic [OFF_W-1:0]  rbase_q, rbase_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              sel_d;
  logic              v_d;
  rblk_tag_t         tag_d;

  logic last_col, last_row, last_bx, blk_end, band_end, img_end;
  logic [OFF_W-1:0] off;

  assign re       = band_full[sel] && (!rd_valid || rd_ready);
  assign last_col = (col_q == 3'd7);
  assign last_row = (row_q == 3'd7);
  assign last_bx  = (WID_W'(bx_q) == (cfg_width >> 3) - WID_W'(1));
  assign blk_end  = last_col && last_row;
  assign band_end = blk_end && last_bx;
  assign img_end  = band_end && (bcnt_q == cfg_bands - BCNT_W'(1));
  assign band_clr = re && band_end;

  // Offset inside a band: row stride is the image width, tile step is 8.
  assign off   = rbase_q + OFF_W'({bx_q, 3'b000}) + OFF_W'(col_q);
  assign raddr = (sel ? ADDR_W'(BAND_DEPTH) : ADDR_W'(0)) + ADDR_W'(off);

  always_comb begin
    col_d   = col_q;
    row_d   = row_q;
    bx_d    = bx_q;
    rbase_d = rbase_q;
    bcnt_d  = bcnt_q;
    sel_d   = sel;
    tag_d   = tag;
    v_d     = rd_valid;
    if (re) begin
      v_d   = 1'b1;
      tag_d = '{blk_last: blk_end, band_done: band_end, img_end: img_end};
      col_d = col_q + 3'd1;
      if (last_col) begin
        if (last_row) begin
          row_d   = '0;
          rbase_d = '0;
          if (last_bx) begin
            bx_d   = '0;
            sel_d  = !sel;
            bcnt_d = img_end ? '0 : bcnt_q + BCNT_W'(1);
          end else begin
            bx_d = bx_q + BX_W'(1);
          end
        end else begin
          row_d   = row_q + 3'd1;
          rbase_d = rbase_q + OFF_W'(cfg_width);
        end
      end
    end else if (rd_ready) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      bx_q     <= '0;
      rbase_q  <= '0;
      bcnt_q   <= '0;
      sel      <= 1'b0;
      rd_valid <= 1'b0;
      tag      <= '0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      bx_q     <= bx_d;
      rbase_q  <= rbase_d;
      bcnt_q   <= bcnt_d;
      sel      <= sel_d;
      rd_valid <= v_d;
      tag      <= tag_d;
    end
  end
endmodule

// File: rtl/rblk_buffer.sv
module rblk_buffer
  import rblk_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int MAX_W     = 64,
  parameter int MAX_BANDS = 256,
  localparam int WID_W    = $clog2(MAX_W + 1),
  localparam int BCNT_W   = $clog2(MAX_BANDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [BCNT_W-1:0] cfg_bands,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [PIX_W-1:0]  wr_pix,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PIX_W-1:0]  rd_pix,
  output logic              rd_blk_last,
  output logic              rd_band_done,
  output logic              rd_eoi
);
  localparam int DEPTH  = NBANDS * TILE * MAX_W;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFF_W  = $clog2(TILE * MAX_W);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wsel, rsel, band_filled, band_clr;
  logic [NBANDS-1:0] full;
  rblk_tag_t         tag;

  rblk_wr_ctrl #(
    .MAX_W (MAX_W),
    .WID_W (WID_W),
    .OFF_W (OFF_W),
    .ADDR_W(ADDR_W)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_width  (cfg_width),
    .wr_valid   (wr_valid),
    .band_busy  (full[wsel]),
    .wr_ready   (wr_ready),
    .we         (we),
    .waddr      (waddr),
    .sel        (wsel),
    .band_filled(band_filled)
  );

  rblk_band_track u_track (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_en (band_filled),
    .set_sel(wsel),
    .clr_en (band_clr),
    .clr_sel(rsel),
    .full   (full)
  );

  rblk_rd_ctrl #(
    .MAX_W    (MAX_W),
    .MAX_BANDS(MAX_BANDS),
    .WID_W    (WID_W),
    .BCNT_W   (BCNT_W),
    .OFF_W    (OFF_W),
    .ADDR_W   (ADDR_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_width(cfg_width),
    .cfg_bands(cfg_bands),
    .band_full(full),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .tag      (tag),
    .re       (re),
    .raddr    (raddr),
    .band_clr (band_clr),
    .sel      (rsel)
  );

  rblk_ram #(
    .DATA_W(PIX_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wr_pix),
    .re   (re),
    .raddr(raddr),
    .rdata(rd_pix)
  );

  assign rd_blk_last  = tag.blk_last;
  assign rd_band_done = tag.band_done;
  assign rd_eoi       = tag.img_end;
endmodule

// File: rtl/rblk_buffer_chk.sv
module rblk_buffer_chk #(
  parameter int PIX_W  = 8,
  parameter int MAX_W  = 64,
  parameter int WID_W  = $clog2(MAX_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WID_W-1:0] cfg_width,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PIX_W-1:0] rd_pix,
  input logic             rd_blk_last,
  input logic             rd_band_done,
  input logic             rd_eoi
);
  localparam int OCC_W = $clog2(16 * MAX_W + 2) + 1;

  logic [OCC_W-1:0] occ;
  logic [5:0]       out_cnt;
  logic             wr_hs, rd_hs;

  assign wr_hs = wr_valid && wr_ready;
  assign rd_hs = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      out_cnt <= '0;
    end else begin
      occ     <= occ + OCC_W'(wr_hs) - OCC_W'(rd_hs);
      out_cnt <= out_cnt + 6'(rd_hs);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!rd_valid && !wr_ready);
    end
  end

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_pix) && $stable(rd_blk_last)
                              && $stable(rd_band_done) && $stable(rd_eoi));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(16) * OCC_W'(cfg_width) + OCC_W'(1));

  a_r4_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> occ != '0);

  a_r7_tile_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs && rd_blk_last |-> out_cnt == 6'd63);

  a_r8_band_ends_tile: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_band_done |-> rd_blk_last);

  a_r9_image_ends_band: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_eoi |-> rd_band_done);
endmodule

bind rblk_buffer rblk_buffer_chk #(
  .PIX_W(PIX_W),
  .MAX_W(MAX_W),
  .WID_W(WID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_width   (cfg_width),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_pix      (rd_pix),
  .rd_blk_last (rd_blk_last),
  .rd_band_done(rd_band_done),
  .rd_eoi      (rd_eoi)
);

// File: tb/tb_rblk_buffer.sv
module tb_rblk_buffer;
  localparam int PIX_W     = 8;
  localparam int MAX_W     = 64;
  localparam int MAX_BANDS = 256;
  localparam int WID_W     = $clog2(MAX_W + 1);
  localparam int BCNT_W    = $clog2(MAX_BANDS + 1);

  logic              clk;
  logic              rst_n;
  logic [WID_W-1:0]  cfg_width;
  logic [BCNT_W-1:0] cfg_bands;
  logic              wr_valid, wr_ready;
  logic [PIX_W-1:0]  wr_pix;
  logic              rd_valid, rd_ready;
  logic [PIX_W-1:0]  rd_pix;
  logic              rd_blk_last, rd_band_done, rd_eoi;

  rblk_buffer #(.PIX_W(PIX_W), .MAX_W(MAX_W), .MAX_BANDS(MAX_BANDS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_bands(cfg_bands),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_pix(wr_pix),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_pix(rd_pix),
    .rd_blk_last(rd_blk_last), .rd_band_done(rd_band_done), .rd_eoi(rd_eoi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit rd_on = 0;
  int rd_mode = 0;
  int cyc = 0;
  logic [PIX_W+2:0] expq[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] pixval(int f, int line, int x);
    return PIX_W'((line * 13) ^ (x * 5) ^ (f * 71) ^ (line >> 2));
  endfunction

  // Driver side of the scoreboard: expected tile-order items for one frame.
  task automatic push_frame(int f, int w, int nb);
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < w / 8; k++)
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 8; c++) begin
            bit bl = (r == 7) && (c == 7);
            bit bd = bl && (k == w / 8 - 1);
            bit ei = bd && (b == nb - 1);
            expq.push_back({pixval(f, 8 * b + r, 8 * k + c), bl, bd, ei});
          end
  endtask

  task automatic write_range(int f, int w, int start, int n, int gap);
    for (int i = start; i < start + n; i++) begin
      wr_valid = 1'b1;
      wr_pix   = pixval(f, i / w, i % w);
      do @(negedge clk); while (!wr_ready);
      @(posedge clk); #1;
      wr_valid = 1'b0;
      if (gap > 0 && (i % 5) == 0) begin
        for (int g = 0; g < gap; g++) begin
          @(posedge clk); #1;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    rd_ready = rd_on && (rd_mode == 0 || (cyc % 4) != 1);
  end

  // Monitor: pops and compares on each output handshake.
  logic             stall_prev = 1'b0;
  logic [PIX_W+2:0] held_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(rd_valid && {rd_pix, rd_blk_last, rd_band_done, rd_eoi} == held_prev,
            "R5", "output held under stall", int'(rd_pix), int'(held_prev[PIX_W+2:3]));
      if (rd_valid && rd_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected output pixel", int'(rd_pix), -1);
        end else begin
          logic [PIX_W+2:0] e;
          e = expq.pop_front();
          chk(rd_pix == e[PIX_W+2:3], "R3", "tile-order pixel", int'(rd_pix), int'(e[PIX_W+2:3]));
          chk(rd_blk_last == e[2], "R7", "tile end flag", int'(rd_blk_last), int'(e[2]));
          chk(rd_band_done == e[1], "R8", "band end flag", int'(rd_band_done), int'(e[1]));
          chk(rd_eoi == e[0], "R9", "image end flag", int'(rd_eoi), int'(e[0]));
        end
      end
      stall_prev = rd_valid && !rd_ready;
      held_prev  = {rd_pix, rd_blk_last, rd_band_done, rd_eoi};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_pix = '0; rd_ready = 1'b0;
    cfg_width = WID_W'(16); cfg_bands = BCNT_W'(3);
    repeat (3) @(negedge clk);
    chk(!rd_valid, "R1", "rd_valid in reset", int'(rd_valid), 0);
    chk(!wr_ready, "R1", "wr_ready in reset", int'(wr_ready), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_valid, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(wr_ready, "R1", "wr_ready after reset", int'(wr_ready), 1);
    @(posedge clk); #1;

    // Frame 0: width 16, three bands, reader stopped at first.
    push_frame(0, 16, 3);
    write_range(0, 16, 0, 127, 0);
    repeat (5) @(negedge clk);
    chk(!rd_valid, "R4", "no output before band complete", int'(rd_valid), 0);
    @(posedge clk); #1;
    write_range(0, 16, 127, 1, 0);
    repeat (4) @(negedge clk);
    chk(rd_valid, "R4", "output after band complete", int'(rd_valid), 1);
    chk(wr_ready, "R10", "host may fill second band", int'(wr_ready), 1);
    @(posedge clk); #1;
    write_range(0, 16, 128, 128, 0);
    repeat (3) @(negedge clk);
    chk(!wr_ready, "R6", "host held off with both bands full", int'(wr_ready), 0);
    repeat (3) @(negedge clk);
    chk(!wr_ready, "R6", "host still held off", int'(wr_ready), 0);
    @(posedge clk); #1;
    rd_mode = 1; rd_on = 1'b1;
    write_range(0, 16, 256, 128, 2);
    drain();

    // Frame 1: maximum width, two bands, reader always ready, host with gaps.
    cfg_width = WID_W'(MAX_W); cfg_bands = BCNT_W'(2);
    rd_mode = 0;
    push_frame(1, MAX_W, 2);
    write_range(1, MAX_W, 0, 16 * MAX_W, 1);
    drain();

    // Frame 2: single tile image, irregular reader.
    cfg_width = WID_W'(8); cfg_bands = BCNT_W'(1);
    rd_mode = 1;
    push_frame(2, 8, 1);
    write_range(2, 8, 0, 64, 3);
    drain();
    repeat (3) @(negedge clk);
    chk(!rd_valid, "R9", "nothing after image end", int'(rd_valid), 0);
    chk(wr_ready, "R2", "ready for next image", int'(wr_ready), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule